// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a digital "supply is above its trip level" indication into an active-low system reset for a microcontroller. The indication comes from an external comparator and is already synchronised to the block clock. While the supply is good, the reset line is left released. When the supply fails, the block pulls the line low. After power returns, the block keeps reset asserted until the supply has stayed good for a timeout counted in clock cycles. The default count gives about 200 ms at 250 MHz. A parameter shortens it for simulation.

A short dip below the trip level is filtered out. The supply-low condition has to be seen on a parameterised number of consecutive samples before it counts as a failure. The default of 8 samples at 250 MHz rejects dips of roughly 30 ns. A failure that passes the filter asserts reset on the next edge. If the timeout is still running, the failure restarts it from zero. The pin is modelled as open-drain: the block only enables a pull-down, so other devices can share the reset line. The same reset state drives a write-lockout signal to a memory controller.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_n` is low, `drive_low`, `reset_active` and `mem_wr_lock` are all 1 (reset asserted).
- R2: If `supply_ok` is sampled high on clock edge j and no qualifying dip follows, the three outputs go to 0 just after edge j+TIMEOUT_CYCLES. They are still 1 after edge j+TIMEOUT_CYCLES-1.
- R3: A qualifying dip is `supply_ok` sampled low on GLITCH_SAMPLES consecutive edges. If the first low sample is on edge k, reset is 1 just after edge k+GLITCH_SAMPLES.
- R4: While released, a low run of fewer than GLITCH_SAMPLES samples leaves all outputs at 0.
- R5: During the timeout, a low run shorter than GLITCH_SAMPLES does not delay the release. It still happens after edge j+TIMEOUT_CYCLES.
- R6: A qualifying dip during the timeout restarts the count from zero. The release then comes TIMEOUT_CYCLES edges after the first high sample that follows the dip.
- R7: `mem_wr_lock` and `reset_active` always equal `drive_low`.
- R8: Reset stays asserted for as long as `supply_ok` stays low.
- R9: If a dip qualifies on the same edge that the timeout would end, reset stays asserted and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supply_ok | input | 1 | Synchronised comparator output, 1 when supply is above trip level |
| drive_low | output | 1 | Pull-down enable of the open-drain reset pin (1 = pull low) |
| reset_active | output | 1 | Status: reset currently asserted |
| mem_wr_lock | output | 1 | Write lockout to memory controller, 1 while reset is asserted |

## Verification
Two functions can act on the same edge: the timeout reaching its final count, and the glitch filter qualifying a dip. The bench raises the supply and waits exactly TIMEOUT_CYCLES-GLITCH_SAMPLES cycles. It then drops the supply, so the dip's last required low sample lands on the same edge as the terminal count. The expected result is that reset stays asserted and the full timeout starts again. Both the cycle-by-cycle model and explicit checks at that edge and at the new release edge judge this.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic {
    SEQ_HOLD = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction
endpackage

// File: rtl/ssr_dip_filter.sv
module ssr_dip_filter #(
  parameter int unsigned GLITCH_SAMPLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic dip_hit
);
  localparam int unsigned FW = ssr_pkg::cnt_bits(GLITCH_SAMPLES + 1);
  localparam logic [FW-1:0] FULL = FW'(GLITCH_SAMPLES);

  logic [FW-1:0] run_q, run_d;
  logic          run_en;

  // Count consecutive low samples, saturating at the qualify level.
  always_comb begin
    run_en = 1'b1;
    run_d  = run_q;
    if (supply_ok) begin
      run_d = '0;
    end else if (run_q == FULL) begin
      run_en = 1'b0;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  // Reset value treats the supply as failed until proven good.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= FULL;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  assign dip_hit = (run_q == FULL);

  assert_good_sample_clears_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok |=> !dip_hit);
  assert_dip_needs_low_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dip_hit) |-> $past(!supply_ok));
endmodule

// File: rtl/ssr_hold_timer.sv
module ssr_hold_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic at_limit
);
  localparam int unsigned TW = ssr_pkg::cnt_bits(TIMEOUT_CYCLES);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear | count_en;
    cnt_d  = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (count_en) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign at_limit = (cnt_q == LAST);

  assert_count_in_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_clear_restarts_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/ssr_release_fsm.sv
module ssr_release_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic dip_hit,
  input  logic at_limit,
  output logic timer_clear,
  output logic timer_en,
  output logic holding
);
  import ssr_pkg::*;

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (dip_hit) begin
      state_d = SEQ_HOLD;
    end else if (state_q == SEQ_HOLD && at_limit) begin
      state_d = SEQ_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_HOLD;
    end else begin
      state_q <= state_d;
    end
  end

  assign timer_clear = dip_hit;
  assign timer_en    = (state_q == SEQ_HOLD);
  assign holding     = (state_q == SEQ_HOLD);

  assert_dip_asserts_reset_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    dip_hit |=> holding);
  assert_release_only_at_limit_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holding) |-> $past(at_limit) && $past(!dip_hit));
  assert_release_sticks_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (!holding && !dip_hit) |=> !holding);
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int unsigned TIMEOUT_CYCLES = 50_000_000,
  parameter int unsigned GLITCH_SAMPLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic drive_low,
  output logic reset_active,
  output logic mem_wr_lock
);
  logic dip_hit;
  logic at_limit;
  logic timer_clear;
  logic timer_en;
  logic holding;

  ssr_dip_filter #(.GLITCH_SAMPLES(GLITCH_SAMPLES)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .dip_hit   (dip_hit)
  );

  ssr_hold_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (timer_clear),
    .count_en (timer_en),
    .at_limit (at_limit)
  );

  ssr_release_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .dip_hit     (dip_hit),
    .at_limit    (at_limit),
    .timer_clear (timer_clear),
    .timer_en    (timer_en),
    .holding     (holding)
  );

  assign drive_low    = holding;
  assign reset_active = holding;
  assign mem_wr_lock  = holding;

  assert_held_while_low_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!supply_ok) && !supply_ok && dip_hit) |=> drive_low);
endmodule

// File: tb/tb_supply_reset_seq.sv
module tb_supply_reset_seq;
  localparam int T = 20;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok;
  logic drive_low, reset_active, mem_wr_lock;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R1";

  // Behavioural reference: consecutive-low run, good-time counter, released flag.
  int  m_run;
  int  m_good;
  bit  m_rel;

  always #2 clk = ~clk;

  supply_reset_seq #(.TIMEOUT_CYCLES(T), .GLITCH_SAMPLES(N)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .drive_low    (drive_low),
    .reset_active (reset_active),
    .mem_wr_lock  (mem_wr_lock)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = N; m_good = 0; m_rel = 0;
    end else begin
      if (m_run >= N) begin
        m_rel = 0; m_good = 0;
      end else if (!m_rel) begin
        if (m_good == T - 1) begin m_rel = 1; m_good = 0; end
        else m_good = m_good + 1;
      end
      if (supply_ok) m_run = 0;
      else if (m_run < N) m_run = m_run + 1;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    check(cur_req, drive_low, !m_rel);
    check("R7", reset_active, drive_low);
    check("R7", mem_wr_lock, drive_low);
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    supply_ok = 1'b0;
    cycles(3);
    cur_req = "R1";
    check("R1", drive_low, 1'b1);
    check("R1", mem_wr_lock, 1'b1);
    rst_n = 1'b1;

    cur_req = "R8";
    cycles(T + 5);
    check("R8", drive_low, 1'b1);

    // R2: clean power-up
    cur_req = "R2";
    supply_ok = 1'b1;
    cycles(T);
    check("R2", drive_low, 1'b1);
    cycles(1);
    check("R2", drive_low, 1'b0);
    cycles(3);

    // R4: short dip while released
    cur_req = "R4";
    supply_ok = 1'b0;
    cycles(N - 1);
    supply_ok = 1'b1;
    cycles(3);
    check("R4", drive_low, 1'b0);
    check("R4", mem_wr_lock, 1'b0);

    // R3: qualifying dip
    cur_req = "R3";
    supply_ok = 1'b0;
    cycles(N);
    check("R3", drive_low, 1'b0);
    cycles(1);
    check("R3", drive_low, 1'b1);
    cycles(3);

    // R5: short dip during timeout does not delay release
    cur_req = "R5";
    supply_ok = 1'b1;
    cycles(5);
    supply_ok = 1'b0;
    cycles(N - 1);
    supply_ok = 1'b1;
    cycles(T - 5 - (N - 1));
    check("R5", drive_low, 1'b1);
    cycles(1);
    check("R5", drive_low, 1'b0);

    // back to hold
    supply_ok = 1'b0;
    cycles(N + 2);
    check("R3", drive_low, 1'b1);

    // R6: qualifying dip mid-count restarts
    cur_req = "R6";
    supply_ok = 1'b1;
    cycles(8);
    supply_ok = 1'b0;
    cycles(N);
    supply_ok = 1'b1;
    cycles(T);
    check("R6", drive_low, 1'b1);
    cycles(1);
    check("R6", drive_low, 1'b0);

    supply_ok = 1'b0;
    cycles(N + 2);

    // R9: dip qualifies on the terminal-count edge
    cur_req = "R9";
    supply_ok = 1'b1;
    cycles(T - N);
    supply_ok = 1'b0;
    cycles(N);
    check("R9", drive_low, 1'b1);
    cycles(1);
    check("R9", drive_low, 1'b1);
    supply_ok = 1'b1;
    cycles(T);
    check("R9", drive_low, 1'b1);
    cycles(1);
    check("R9", drive_low, 1'b0);
    cycles(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule